// File: doc/BRIEF.md
# Phase-Frequency Detector with Digital Lock Flag

This block compares two divided pulse trains inside a synthesizer loop: `ref_div`, which comes from the reference divider, and `fb_div`, which comes from the feedback divider. Both are asynchronous to the sample clock. Each input passes through a synchronizer chain and a rising-edge detector. A four-state tri-state detector then turns the edge order into charge-pump commands. `up` is raised when the reference edge arrives first, so charge is sourced. `dn` is raised when the feedback edge arrives first, so charge is sunk. `activity` is the OR of `up` and `dn`.

The lock flag is `unlocked_n`. It is driven low while the loop is out of lock and goes high once lock is declared. It is the inverted, low-pass-filtered form of `activity`. The filter is a saturating level counter. It rises by one on every sample cycle with activity and falls by one on every quiet cycle. A two-state qualifier, with states ACQUIRE and HELD, declares lock once the level has stayed below `lock_thresh` for `lock_periods` consecutive reference edges. It leaves lock as soon as the level reaches the threshold.

Detector states and transitions:
- From IDLE, a lone reference edge goes to LEAD. A lone feedback edge goes to LAG. Coincident edges stay in IDLE.
- From LEAD, a feedback edge goes to CLEAR.
- From LAG, a reference edge goes to CLEAR.
- CLEAR always returns to IDLE.

Qualifier transitions:
- ACQUIRE goes to HELD on the qualifying reference edge.
- HELD goes to ACQUIRE when the level reaches the threshold.

Top module: `pfd_lock_detector`

## Requirements
- R1: When a reference rising edge arrives with no feedback edge pending, `up` goes high. With the default two synchronizer stages, `up` is visible after the third sample-clock rising edge following the input change. `up` stays high until a feedback edge arrives. `dn` stays low during this time.
- R2: When a feedback rising edge arrives with no reference edge pending, `dn` goes high with the same latency as in R1. `dn` stays high until a reference edge arrives. `up` stays low during this time.
- R3: Once the second edge of a pair is seen, `up` and `dn` are both high for exactly one sample cycle and then both go low. Any edge detected during that one cycle is ignored.
- R4: A reference edge and a feedback edge detected in the same sample cycle produce no pulse on `up` or `dn`.
- R5: `activity` equals `up` OR `dn` in every cycle.
- R6: The level counter increments on each cycle with activity and decrements on each quiet cycle. It saturates at 0 and at 2^LEVEL_W-1 and never wraps.
- R7: Lock is declared once `lock_periods` consecutive reference edges are each seen with the level below `lock_thresh`. Any cycle in ACQUIRE with the level at or above the threshold restarts the count. A `lock_periods` value of 0 acts as 1. A `lock_thresh` value of 0 never locks.
- R8: `unlocked_n` is 0 while out of lock and 1 while in lock. In lock, a level reaching `lock_thresh` drops the flag back to 0.
- R9: An active-low `rst_n` asynchronously clears `up`, `dn`, `activity`, the level counter and the qualifier, and forces `unlocked_n` to 0.
- R10: Falling edges on `ref_div` or `fb_div` have no effect on `up` or `dn`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ref_div | input | 1 | Divided reference pulse train, asynchronous |
| fb_div | input | 1 | Divided feedback pulse train, asynchronous |
| lock_thresh | input | LEVEL_W | Level at or above which the loop counts as out of lock |
| lock_periods | input | QUAL_W | Consecutive quiet reference edges needed to declare lock |
| up | output | 1 | Charge-source command |
| dn | output | 1 | Charge-sink command |
| activity | output | 1 | OR of `up` and `dn` |
| unlocked_n | output | 1 | Low while out of lock, high while in lock |

## Verification
The hardest condition to reach is the saturated level counter. It is the only state that separates saturating arithmetic from wrap-around arithmetic, and it can only be seen indirectly through the lock flag. The bench creates it by holding a reference edge pending for twenty cycles without a matching feedback edge, which drives the level to its maximum. It then sends a coincident edge pair at a point where a saturated level would still be above the threshold but a wrapped level would already have decayed to zero. A second difficult case is an edge landing in the single CLEAR cycle. The bench reaches it by launching a fresh reference edge exactly one cycle after the feedback edge that closes a LEAD interval.

// File: rtl/pfd_lock_pkg.sv
package pfd_lock_pkg;

    typedef enum logic [1:0] {
        PD_IDLE  = 2'd0,
        PD_LEAD  = 2'd1,
        PD_LAG   = 2'd2,
        PD_CLEAR = 2'd3
    } pd_state_t;

    typedef enum logic {
        LK_ACQUIRE = 1'b0,
        LK_HELD    = 1'b1
    } lk_state_t;

endpackage

// File: rtl/pfd_edge_sync.sv
module pfd_edge_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic async_in,
    output logic rise
);
    logic [STAGES-1:0] sync_q;
    logic              prev_q;

    generate
        for (genvar i = 0; i < STAGES; i++) begin : g_stage
            if (i == 0) begin : g_first
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n) sync_q[0] <= 1'b0;
                    else        sync_q[0] <= async_in;
                end
            end else begin : g_next
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n) sync_q[i] <= 1'b0;
                    else        sync_q[i] <= sync_q[i-1];
                end
            end
        end
    endgenerate

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) prev_q <= 1'b0;
        else        prev_q <= sync_q[STAGES-1];
    end

    assign rise = sync_q[STAGES-1] & ~prev_q;

    // R10
    rise_single_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rise |=> !rise);

endmodule

// File: rtl/pfd_tristate_core.sv
module pfd_tristate_core
    import pfd_lock_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic ref_rise,
    input  logic fb_rise,
    output logic up,
    output logic dn
);
    pd_state_t state_q, state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= PD_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            PD_IDLE: begin
                if (ref_rise && !fb_rise)      state_d = PD_LEAD;
                else if (fb_rise && !ref_rise) state_d = PD_LAG;
            end
            PD_LEAD:  if (fb_rise)  state_d = PD_CLEAR;
            PD_LAG:   if (ref_rise) state_d = PD_CLEAR;
            PD_CLEAR: state_d = PD_IDLE;
            default:  state_d = PD_IDLE;
        endcase
    end

    always_comb begin
        up = (state_q == PD_LEAD) || (state_q == PD_CLEAR);
        dn = (state_q == PD_LAG)  || (state_q == PD_CLEAR);
    end

    // R3
    both_one_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (up && dn) |=> (!up && !dn));
    // R1
    up_needs_ref_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(up) |-> $past(ref_rise));
    // R2
    dn_needs_fb_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(dn) |-> $past(fb_rise));
    // R4
    coincident_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!up && !dn && ref_rise && fb_rise) |=> (!up && !dn));

endmodule

// File: rtl/pfd_quiet_filter.sv
module pfd_quiet_filter
    import pfd_lock_pkg::*;
#(
    parameter int LEVEL_W = 4,
    parameter int QUAL_W  = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               activity,
    input  logic               ref_rise,
    input  logic [LEVEL_W-1:0] lock_thresh,
    input  logic [QUAL_W-1:0]  lock_periods,
    output logic               unlocked_n
);
    localparam logic [LEVEL_W-1:0] LEVEL_MAX = {LEVEL_W{1'b1}};

    logic [LEVEL_W-1:0] level_q;
    logic [QUAL_W-1:0]  qual_q, qual_d;
    lk_state_t          lk_q, lk_d;
    logic               quiet;
    logic [QUAL_W:0]    qual_next;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                          level_q <= '0;
        else if (activity && level_q != LEVEL_MAX) level_q <= level_q + 1'b1;
        else if (!activity && level_q != '0)       level_q <= level_q - 1'b1;
    end

    assign quiet     = level_q < lock_thresh;
    assign qual_next = {1'b0, qual_q} + 1'b1;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            lk_q   <= LK_ACQUIRE;
            qual_q <= '0;
        end else begin
            lk_q   <= lk_d;
            qual_q <= qual_d;
        end
    end

    always_comb begin
        lk_d   = lk_q;
        qual_d = qual_q;
        unique case (lk_q)
            LK_ACQUIRE: begin
                if (!quiet) begin
                    qual_d = '0;
                end else if (ref_rise) begin
                    if (qual_next >= {1'b0, lock_periods}) begin
                        lk_d   = LK_HELD;
                        qual_d = '0;
                    end else begin
                        qual_d = qual_next[QUAL_W-1:0];
                    end
                end
            end
            LK_HELD: begin
                if (!quiet) begin
                    lk_d   = LK_ACQUIRE;
                    qual_d = '0;
                end
            end
            default: begin
                lk_d   = LK_ACQUIRE;
                qual_d = '0;
            end
        endcase
    end

    always_comb unlocked_n = (lk_q == LK_HELD);

    // R6
    level_no_wrap_up_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (activity && level_q == LEVEL_MAX) |=> (level_q == LEVEL_MAX));
    // R6
    level_no_wrap_down_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!activity && level_q == '0) |=> (level_q == '0));
    // R7
    lock_on_ref_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(unlocked_n) |-> $past(ref_rise));
    // R8
    lock_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (unlocked_n && !quiet) |=> !unlocked_n);

endmodule

// File: rtl/pfd_lock_detector.sv
module pfd_lock_detector #(
    parameter int SYNC_STAGES = 2,
    parameter int LEVEL_W     = 4,
    parameter int QUAL_W      = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               ref_div,
    input  logic               fb_div,
    input  logic [LEVEL_W-1:0] lock_thresh,
    input  logic [QUAL_W-1:0]  lock_periods,
    output logic               up,
    output logic               dn,
    output logic               activity,
    output logic               unlocked_n
);
    logic ref_rise, fb_rise;

    pfd_edge_sync #(.STAGES(SYNC_STAGES)) u_ref_sync (
        .clk(clk), .rst_n(rst_n), .async_in(ref_div), .rise(ref_rise));

    pfd_edge_sync #(.STAGES(SYNC_STAGES)) u_fb_sync (
        .clk(clk), .rst_n(rst_n), .async_in(fb_div), .rise(fb_rise));

    pfd_tristate_core u_core (
        .clk(clk), .rst_n(rst_n), .ref_rise(ref_rise), .fb_rise(fb_rise),
        .up(up), .dn(dn));

    assign activity = up | dn;

    pfd_quiet_filter #(.LEVEL_W(LEVEL_W), .QUAL_W(QUAL_W)) u_filter (
        .clk(clk), .rst_n(rst_n), .activity(activity), .ref_rise(ref_rise),
        .lock_thresh(lock_thresh), .lock_periods(lock_periods),
        .unlocked_n(unlocked_n));

    // R9
    reset_outputs_chk: assert property (@(posedge clk)
        !rst_n |-> (!up && !dn && !unlocked_n));

endmodule

// File: tb/pfd_lock_detector_bench.sv
module pfd_lock_detector_bench;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       ref_div = 1'b0;
    logic       fb_div = 1'b0;
    logic [3:0] lock_thresh = 4'd3;
    logic [7:0] lock_periods = 8'd4;
    logic       up, dn, activity, unlocked_n;

    int checks = 0;
    int errors = 0;

    always #10 clk = ~clk;

    pfd_lock_detector u_pfd_lock_detector (
        .clk(clk), .rst_n(rst_n), .ref_div(ref_div), .fb_div(fb_div),
        .lock_thresh(lock_thresh), .lock_periods(lock_periods),
        .up(up), .dn(dn), .activity(activity), .unlocked_n(unlocked_n));

    task automatic step(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic chk(input string tag, input logic [3:0] act, input logic [3:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%b expected=%b at %0t", tag, act, exp, $time);
        end
    endtask

    // Output vector order: {up, dn, activity, unlocked_n}
    function automatic logic [3:0] outs();
        return {up, dn, activity, unlocked_n};
    endfunction

    task automatic apply_reset();
        @(negedge clk);
        rst_n = 1'b0; ref_div = 1'b0; fb_div = 1'b0;
        step(3);
        rst_n = 1'b1;
        step(1);
    endtask

    task automatic t_reset_state();
        apply_reset();
        chk("R9 reset outputs", outs(), 4'b0000);
    endtask

    task automatic t_ref_leads();
        ref_div = 1'b1;
        step(2);
        chk("R1 up not yet", outs(), 4'b0000);
        step(1);
        chk("R1 up on ref edge, R5 activity", outs(), 4'b1010);
        fb_div = 1'b1;
        step(2);
        chk("R1 up held", outs(), 4'b1010);
        step(1);
        chk("R3 both high", outs(), 4'b1110);
        step(1);
        chk("R3 both cleared", outs(), 4'b0000);
        ref_div = 1'b0; fb_div = 1'b0;
        step(4);
        chk("R10 falling edges ignored", outs(), 4'b0000);
    endtask

    task automatic t_fb_leads();
        fb_div = 1'b1;
        step(3);
        chk("R2 dn on fb edge, R5 activity", outs(), 4'b0110);
        fb_div = 1'b0;
        step(4);
        chk("R2 dn held, R10 fall ignored", outs(), 4'b0110);
        ref_div = 1'b1;
        step(3);
        chk("R3 both high after lag", outs(), 4'b1110);
        step(1);
        chk("R3 both cleared after lag", outs(), 4'b0000);
        ref_div = 1'b0;
        step(4);
    endtask

    task automatic t_coincident();
        ref_div = 1'b1; fb_div = 1'b1;
        for (int i = 0; i < 6; i++) begin
            step(1);
            chk("R4 coincident no pulse", outs(), 4'b0000);
        end
        ref_div = 1'b0; fb_div = 1'b0;
        step(4);
    endtask

    task automatic t_clear_ignores();
        ref_div = 1'b1;
        step(1);
        ref_div = 1'b0;
        step(2);
        chk("R1 lead before clear", outs(), 4'b1010);
        fb_div = 1'b1;
        step(1);
        ref_div = 1'b1;
        step(2);
        chk("R3 clear cycle", outs(), 4'b1110);
        for (int i = 0; i < 4; i++) begin
            step(1);
            chk("R3 edge in clear ignored", outs(), 4'b0000);
        end
        ref_div = 1'b0; fb_div = 1'b0;
        step(4);
    endtask

    task automatic t_reset_mid();
        ref_div = 1'b1;
        step(3);
        chk("R1 up before reset", outs(), 4'b1010);
        rst_n = 1'b0;
        ref_div = 1'b0;
        step(1);
        chk("R9 async reset clears", outs(), 4'b0000);
        rst_n = 1'b1;
        step(4);
        chk("R9 stays idle after reset", outs(), 4'b0000);
    endtask

    task automatic clean_pulse(input int period);
        ref_div = 1'b1; fb_div = 1'b1;
        step(2);
        ref_div = 1'b0; fb_div = 1'b0;
        step(period - 2);
    endtask

    task automatic bad_pulse(input int period);
        ref_div = 1'b1;
        step(1);
        ref_div = 1'b0;
        step(4);
        fb_div = 1'b1;
        step(1);
        fb_div = 1'b0;
        step(period - 6);
    endtask

    task automatic t_lock_acquire();
        lock_thresh = 4'd3; lock_periods = 8'd4;
        apply_reset();
        clean_pulse(16);
        clean_pulse(16);
        chk("R8 unlocked during acquire", outs(), 4'b0000);
        bad_pulse(16);
        clean_pulse(16);
        clean_pulse(16);
        clean_pulse(16);
        chk("R7 count restarted by activity", outs(), 4'b0000);
        clean_pulse(16);
        chk("R7 R8 locked after consecutive quiet edges", outs(), 4'b0001);
    endtask

    task automatic t_lock_loss();
        ref_div = 1'b1;
        step(1);
        ref_div = 1'b0;
        step(4);
        fb_div = 1'b1;
        step(1);
        fb_div = 1'b0;
        step(6);
        chk("R8 lock lost on activity", outs(), 4'b0000);
        step(10);
    endtask

    task automatic t_saturation();
        lock_thresh = 4'd2; lock_periods = 8'd1;
        apply_reset();
        ref_div = 1'b1;
        step(1);
        ref_div = 1'b0;
        step(19);
        fb_div = 1'b1;
        step(1);
        fb_div = 1'b0;
        step(9);
        clean_pulse(5);
        chk("R6 level saturated, no lock yet", outs(), 4'b0000);
        step(15);
        clean_pulse(6);
        chk("R6 R7 relock after decay", outs(), 4'b0001);
    endtask

    task automatic t_zero_thresh();
        lock_thresh = 4'd0; lock_periods = 8'd0;
        apply_reset();
        clean_pulse(8);
        clean_pulse(8);
        chk("R7 zero threshold never locks", outs(), 4'b0000);
        lock_thresh = 4'd3;
        clean_pulse(8);
        chk("R7 zero periods acts as one", outs(), 4'b0001);
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin : main
        t_reset_state();
        t_ref_leads();
        t_fb_leads();
        t_coincident();
        t_clear_ignores();
        t_reset_mid();
        t_lock_acquire();
        t_lock_loss();
        t_saturation();
        t_zero_thresh();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule